// File: doc/BRIEF.md
# Frame Parity (BIP-8) Monitor with Bit-Error Count

This block watches one STS-12 byte stream and measures its bit error rate through the line parity byte. Every byte of a frame, taken before descrambling, is folded into an 8-bit even-parity accumulator. The parity gathered over one whole frame is held and then compared with the parity byte that the following frame carries. That byte is read from the descrambled stream at a fixed offset from the frame start.

Each disagreeing bit position adds one to a saturating error counter. Software reads the counter and clears it with a one-cycle strobe. A one-cycle pulse marks every frame whose parity check found at least one mismatching bit. The frame start strobe comes from the upstream descrambler and is high on the first framing byte. One byte arrives on every clock.

Top module: `bip8_frame_monitor`

## Requirements
- R1: After reset, and until the first comparison, `err_count` is 0 and `err_pulse` is 0.
- R2: Bit i of the frame parity is the XOR of bit i of every `scr_byte` from the byte marked by `frm_start` up to the byte before the next `frm_start`.
- R3: The stored parity is compared only with `dscr_byte` on the byte at offset `B1_OFFSET` after `frm_start` (default 1080, where the `frm_start` byte is offset 0). `dscr_byte` at any other offset does not affect the result.
- R4: The parity byte of the first frame after reset is not compared, because no complete earlier frame exists. That frame therefore leaves `err_count` unchanged.
- R5: On the clock after the parity byte is sampled, `err_count` rises by the number of mismatching bit positions, from 0 to 8.
- R6: `err_pulse` is high for exactly one cycle, the cycle after the parity byte is sampled, when the mismatch is nonzero. Otherwise it is low.
- R7: `err_count` is `CNT_W` bits wide (default 16). It stops at its all-ones value and never wraps.
- R8: A high `rd_clr` clears `err_count` on the next clock. If a mismatch increment falls in that same cycle, the count becomes that increment.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | High on the first framing byte of each frame |
| scr_byte | input | DATA_W | Byte before descrambling |
| dscr_byte | input | DATA_W | Same byte after descrambling |
| rd_clr | input | 1 | Read-and-clear strobe for the error counter |
| err_count | output | CNT_W | Saturating count of errored parity bits |
| err_pulse | output | 1 | One-cycle flag for a frame with parity errors |

## Verification
Both results come from one register stage. `err_count` and `err_pulse` change on the clock edge that samples the parity byte, so they can be observed from the falling edge after it. The bench predicts the next count and pulse from each byte it drives, before that byte reaches the design. It then compares the outputs at the following falling edge, on every cycle. Read-and-clear strobes are placed both on an ordinary byte and on the parity byte itself, so the coincident case is checked against its own expected value.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
   // Comparison readiness: no frame seen, first frame running, reference held
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FIRST = 2'd1,
      PH_RUN   = 2'd2
   } frm_phase_t;
endpackage

// File: rtl/bip8_frame_timer.sv
module bip8_frame_timer
   import bip8_pkg::*;
#(
   parameter int FRAME_BYTES = 9720,
   parameter int B1_OFFSET   = 1080
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frm_start,
   output logic b1_hit
);
   localparam int POS_W = $clog2(FRAME_BYTES + 1);
   localparam logic [POS_W-1:0] POS_B1  = POS_W'(B1_OFFSET);
   localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_BYTES - 1);

   generate
      if (B1_OFFSET < 1 || B1_OFFSET >= FRAME_BYTES) begin : g_bad_offset
         $error("B1_OFFSET must lie inside the frame and after its first byte");
      end
   endgenerate

   frm_phase_t       phase_q;
   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else if (frm_start) begin
         case (phase_q)
            PH_IDLE:  phase_q <= PH_FIRST;
            default:  phase_q <= PH_RUN;
         endcase
      end
   end

   // pos_q holds the offset of the current byte when frm_start is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (frm_start) begin
         pos_q <= POS_W'(1);
      end else if (phase_q != PH_IDLE && pos_q != POS_END) begin
         pos_q <= pos_q + POS_W'(1);
      end
   end

   assign b1_hit = (phase_q == PH_RUN) && !frm_start && (pos_q == POS_B1);

   // R3
   b1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b1_hit |=> !b1_hit);

   // R4
   b1_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_RUN) |-> !b1_hit);
endmodule

// File: rtl/bip8_parity_acc.sv
module bip8_parity_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic [DATA_W-1:0] scr_byte,
   output logic [DATA_W-1:0] ref_par
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] ref_q;

   // One independent even-parity lane per bit position
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q[b] <= 1'b0;
            ref_q[b] <= 1'b0;
         end else if (frm_start) begin
            acc_q[b] <= scr_byte[b];
            ref_q[b] <= acc_q[b];
         end else begin
            acc_q[b] <= acc_q[b] ^ scr_byte[b];
         end
      end
   end

   assign ref_par = ref_q;

   // R2
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_start |=> $stable(ref_q));
endmodule

// File: rtl/bip8_mismatch.sv
module bip8_mismatch #(
   parameter int DATA_W = 8,
   parameter int INC_W  = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] ref_par,
   input  logic [DATA_W-1:0] b1_byte,
   output logic [INC_W-1:0]  nbits
);
   logic [DATA_W-1:0] diff;

   assign diff = ref_par ^ b1_byte;

   always_comb begin
      nbits = '0;
      for (int i = 0; i < DATA_W; i++) begin
         nbits = nbits + INC_W'(diff[i]);
      end
   end
endmodule

// File: rtl/bip8_err_counter.sv
module bip8_err_counter #(
   parameter int CNT_W = 16,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc_val,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             pulse
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < INC_W) begin : g_bad_cnt
         $error("CNT_W must hold a full per-frame increment");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;

   assign base = clr ? '0 : cnt_q;
   assign sum  = {1'b0, base} + (CNT_W + 1)'(inc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= inc_en && (inc_val != '0);
         if (inc_en) begin
            cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
         end else begin
            cnt_q <= base;
         end
      end
   end

   assign count = cnt_q;

   // R7
   count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   // R5
   count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q >= $past(cnt_q)));

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc_en) |=> (cnt_q == '0));
endmodule

// File: rtl/bip8_frame_monitor.sv
module bip8_frame_monitor #(
   parameter int DATA_W      = 8,
   parameter int FRAME_BYTES = 9720,
   parameter int B1_OFFSET   = 1080,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic [DATA_W-1:0] scr_byte,
   input  logic [DATA_W-1:0] dscr_byte,
   input  logic              rd_clr,
   output logic [CNT_W-1:0]  err_count,
   output logic              err_pulse
);
   localparam int INC_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              b1_hit;
   logic [DATA_W-1:0] ref_par;
   logic [INC_W-1:0]  nbits;

   bip8_frame_timer #(
      .FRAME_BYTES (FRAME_BYTES),
      .B1_OFFSET   (B1_OFFSET)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .b1_hit    (b1_hit)
   );

   bip8_parity_acc #(
      .DATA_W (DATA_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .scr_byte  (scr_byte),
      .ref_par   (ref_par)
   );

   bip8_mismatch #(
      .DATA_W (DATA_W),
      .INC_W  (INC_W)
   ) u_cmp (
      .ref_par (ref_par),
      .b1_byte (dscr_byte),
      .nbits   (nbits)
   );

   bip8_err_counter #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (b1_hit),
      .inc_val (nbits),
      .clr     (rd_clr),
      .count   (err_count),
      .pulse   (err_pulse)
   );

   // R6
   pulse_moves_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(rd_clr) || err_count != $past(err_count) || err_count == CNT_MAX));

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);
endmodule

// File: tb/sim_bip8_frame_monitor.sv
`timescale 1ns/1ps
module sim_bip8_frame_monitor;
   localparam int FB   = 16;
   localparam int OFF  = 3;
   localparam int CW   = 6;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frm_start = 1'b0;
   logic [7:0]    scr_byte = '0;
   logic [7:0]    dscr_byte = '0;
   logic          rd_clr = 1'b0;
   logic [CW-1:0] err_count;
   logic          err_pulse;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   int    exp_cnt = 0;
   bit    exp_pulse = 1'b0;
   int    frames = 0;
   int    pulses = 0;
   bit    live = 1'b0;
   logic [7:0] prev_par = '0;
   string ctx = "R1";

   always #2 clk = ~clk;

   bip8_frame_monitor #(
      .DATA_W      (8),
      .FRAME_BYTES (FB),
      .B1_OFFSET   (OFF),
      .CNT_W       (CW)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .scr_byte  (scr_byte),
      .dscr_byte (dscr_byte),
      .rd_clr    (rd_clr),
      .err_count (err_count),
      .err_pulse (err_pulse)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog (%s): actual cycle %0d expected end before 100000", ctx, cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // One byte: compare the outputs due now, drive the byte, predict the next outputs
   task automatic step(input bit fs, input logic [7:0] s, input logic [7:0] d,
                       input bit clr, input bit cmp, input logic [7:0] mask);
      int nxt;
      @(negedge clk);
      if (live) begin
         check({ctx, " count"}, int'(err_count), exp_cnt);
         check({ctx, " pulse"}, int'(err_pulse), int'(exp_pulse));
         if (err_pulse) pulses++;
      end
      frm_start = fs;
      scr_byte  = s;
      dscr_byte = d;
      rd_clr    = clr;
      nxt = clr ? 0 : exp_cnt;
      if (cmp) begin
         nxt = nxt + $countones(mask);
         if (nxt > CMAX) nxt = CMAX;
         exp_pulse = ($countones(mask) != 0);
      end else begin
         exp_pulse = 1'b0;
      end
      exp_cnt = nxt;
      live = 1'b1;
   endtask

   // pat: 0 random, 1 all zeros, 2 all ones
   task automatic send_frame(input logic [7:0] mask, input int pat, input int clr_at);
      logic [7:0] par = '0;
      logic [7:0] s;
      logic [7:0] d;
      bit         have_ref = (frames > 0);
      pulses = 0;
      for (int j = 0; j < FB; j++) begin
         case (pat)
            1:       s = 8'h00;
            2:       s = 8'hFF;
            default: s = 8'($urandom);
         endcase
         d = 8'($urandom);
         if (j == OFF) d = prev_par ^ mask;
         par = par ^ s;
         step(j == 0, s, d, j == clr_at, (j == OFF) && have_ref, mask);
      end
      prev_par = par;
      frames++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      frm_start = 1'b0;
      rd_clr = 1'b0;
      live = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_cnt = 0;
      exp_pulse = 1'b0;
      frames = 0;
   endtask

   initial begin
      do_reset();
      #1;
      ctx = "R1";
      check("R1 reset count", int'(err_count), 0);
      check("R1 reset pulse", int'(err_pulse), 0);

      ctx = "R4";
      send_frame(8'hFF, 0, -1);
      check("R4 first frame uncompared", int'(err_count), 0);

      ctx = "R2";
      send_frame(8'h00, 1, -1);
      check("R2 zero data parity", int'(err_count), 0);
      send_frame(8'h00, 2, -1);
      check("R2 ones data parity", int'(err_count), 0);

      ctx = "R3";
      send_frame(8'h00, 0, -1);
      check("R3 random data, other bytes ignored", int'(err_count), 0);
      check("R3 no pulse on clean frame", pulses, 0);

      ctx = "R5";
      send_frame(8'h01, 0, -1);
      check("R5 one bit", int'(err_count), 1);
      send_frame(8'hA5, 0, -1);
      check("R5 four bits", int'(err_count), 5);
      send_frame(8'hFF, 0, -1);
      check("R5 eight bits", int'(err_count), 13);

      ctx = "R6";
      send_frame(8'h10, 0, -1);
      check("R6 single pulse", pulses, 1);
      check("R6 count", int'(err_count), 14);

      ctx = "R8";
      send_frame(8'h00, 0, 8);
      check("R8 clear", int'(err_count), 0);
      send_frame(8'h07, 0, OFF);
      check("R8 clear with increment", int'(err_count), 3);

      ctx = "R7";
      for (int k = 0; k < 8; k++) send_frame(8'hFF, 0, -1);
      check("R7 saturated", int'(err_count), CMAX);
      send_frame(8'h01, 0, -1);
      check("R7 stays saturated", int'(err_count), CMAX);

      ctx = "R1";
      do_reset();
      #1;
      check("R1 count after second reset", int'(err_count), 0);
      ctx = "R4";
      send_frame(8'hFF, 0, -1);
      check("R4 first frame after second reset", int'(err_count), 0);
      send_frame(8'h03, 0, -1);
      check("R4 second frame compared", int'(err_count), 2);

      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule